// File: doc/BRIEF.md
# Indexed RTC Register Interface

This block is the host-facing register front end of a real-time clock. A host reaches a 128-byte space through just two byte addresses. A write to the even address picks an index, and accesses to the odd address then read or write the byte at that index. Four of those bytes are control and status registers. The rest form plain general-purpose storage.

The timekeeping logic next to the block sends it single-cycle event pulses for three events: periodic tick, alarm match and update-ended. The block gathers these into a flag register that clears when read. It drives one interrupt line from the flags that software has enabled. In the other direction, it hands the timekeeping logic its control fields: rate select, divider select, set mode, square-wave enable, binary mode and 24-hour mode. The timekeeping logic also reports an update-busy level, which the block shows as a read-only bit.

Two resets exist. The active-low `rst_n` is the power-up reset and loads the default control values. The `sys_rst` pulse is a system reset. It clears only the interrupt-related enables and flags.

Top module: `rtcx_regif`

## Requirements
- R1: A write to the even address latches index bits 6:0 of the data and ignores data bit 7. Odd-address reads and writes reach the byte at the latched index, so index 0x20 and index 0xA0 name the same byte.
- R2: A read of the even address returns 0xFF.
- R3: Writes to the flag register (index 0x0C) and to the status register (index 0x0D) have no effect. The status register always reads 0x80.
- R4: A read of the flag register returns its contents. In the same cycle it clears the whole register and drops `irq`, so a second read returns 0x00.
- R5: Flag register bits 7 down to 4 are: summary, periodic, alarm, update-ended. Control register B bits 6, 5 and 4 are the periodic, alarm and update-ended enables. An event sets its flag. If the flag was clear and its enable is 1, the summary flag and `irq` are set. With the enable at 0, the flag is set but `irq` stays low.
- R6: A write to register B (index 0x0B) whose enable bits match a flag that is already set raises the summary flag and `irq` at once. Any other write to B clears the summary flag and `irq` and leaves the event flags as they are.
- R7: Bit 7 of register A (index 0x0A) reflects the `upd_busy` input and cannot be written. A write to A stores bits 6:0 only.
- R8: Register A bits 3:0 appear on `rate_sel`. A periodic event is dropped, and its flag stays clear, while the periodic enable is 0.
- R9: After power-up reset, registers A, B, C and D read 0x26, 0x02, 0x00 and 0x80.
- R10: A `sys_rst` pulse clears register B bits 6, 5 and 3 (periodic, alarm and square-wave enables), clears all flags and lowers `irq`. Every other bit of B is kept.
- R11: Flag register bits 3:0 always read 0.
- R12: An event that arrives in the same cycle as a read of the flag register is not lost. Its flag is set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| sys_rst | input | 1 | Synchronous system reset pulse (clears enables and flags) |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_odd | input | 1 | Address bit 0: 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| tick_periodic | input | 1 | Periodic event pulse |
| tick_alarm | input | 1 | Alarm event pulse |
| tick_update | input | 1 | Update-ended event pulse |
| upd_busy | input | 1 | Update-in-progress level from timekeeping |
| irq | output | 1 | Interrupt request, active high |
| rate_sel | output | 4 | Periodic rate select (register A bits 3:0) |
| div_sel | output | 3 | Divider select (register A bits 6:4) |
| set_mode | output | 1 | Register B bit 7 |
| sqw_en | output | 1 | Register B bit 3 |
| bin_mode | output | 1 | Register B bit 2 |
| hr24 | output | 1 | Register B bit 1 |

## Verification
The bench builds the block with its default parameters: a 7-bit index and control registers based at index 0x0A. With these values the index-aliasing case of data bit 7 (0x20 against 0xA0) is reachable. So is the shadowing of the general-purpose memory by registers A to D. Directed scenarios cover a flag raised with and without its enable, and late enabling through register B. They also cover a flag read that coincides with an event, and a system reset with mixed B contents.

// File: rtl/rtcx_pkg.sv
// Shared constants and types for the indexed RTC register interface.
// Assumes byte-wide data; bit positions here are decoded by timekeeping logic.
package rtcx_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Register A
    localparam int A_BUSY = 7;
    // Register B
    localparam int B_SET = 7;
    localparam int B_PIE = 6;
    localparam int B_AIE = 5;
    localparam int B_UIE = 4;
    localparam int B_SQW = 3;
    localparam int B_BIN = 2;
    localparam int B_H24 = 1;
    // Register C
    localparam int C_SUM = 7;
    localparam int C_PER = 6;
    localparam int C_ALM = 5;
    localparam int C_UPD = 4;

    localparam byte_t A_POR = 8'h26;
    localparam byte_t B_POR = 8'h02;
    localparam byte_t C_POR = 8'h00;
    localparam byte_t D_VAL = 8'h80;

    typedef enum logic [2:0] {
        SEL_MEM,
        SEL_A,
        SEL_B,
        SEL_C,
        SEL_D
    } rsel_e;

    // Three event sources, ordered to match flag bits 6..4
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_t;
endpackage

// File: rtl/rtcx_bus_port.sv
// Index latch and address decode for the two-port byte bus.
// Assumes one access per strobe cycle; index only ever comes from the even port.
module rtcx_bus_port
    import rtcx_pkg::*;
#(
    parameter int IDX_W     = 7,
    parameter int CTRL_BASE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic             acc_odd,
    input  logic [IDX_W-1:0] idx_wdata,
    output logic [IDX_W-1:0] idx,
    output rsel_e            sel,
    output logic             data_wr,
    output logic             data_rd
);
    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(CTRL_BASE);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(CTRL_BASE + 1);
    localparam logic [IDX_W-1:0] IDX_C = IDX_W'(CTRL_BASE + 2);
    localparam logic [IDX_W-1:0] IDX_D = IDX_W'(CTRL_BASE + 3);

    logic [IDX_W-1:0] idx_q;

    // Latch the index on even-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (acc_en && acc_wr && !acc_odd)
            idx_q <= idx_wdata;
    end

    // Decode the latched index into a register select.
    always_comb begin
        if (idx_q == IDX_A)      sel = SEL_A;
        else if (idx_q == IDX_B) sel = SEL_B;
        else if (idx_q == IDX_C) sel = SEL_C;
        else if (idx_q == IDX_D) sel = SEL_D;
        else                     sel = SEL_MEM;
    end

    assign idx     = idx_q;
    assign data_wr = acc_en && acc_wr && acc_odd;
    assign data_rd = acc_en && !acc_wr && acc_odd;

    // R1: index latch takes the low data bits
    a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !acc_odd) |=> (idx == $past(idx_wdata)));

    // R1: data-port accesses leave the index unchanged
    a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_odd) |=> $stable(idx));
endmodule

// File: rtl/rtcx_gp_mem.sv
// General-purpose byte storage covering the whole index space.
// Assumes the caller masks writes aimed at control indices; no reset on contents.
module rtcx_gp_mem
    import rtcx_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] addr,
    input  byte_t            wdata,
    output byte_t            rdata
);
    localparam int DEPTH = 1 << IDX_W;

    byte_t mem_q [DEPTH];

    // Store a byte on a masked data-port write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/rtcx_ctrl_regs.sv
// Control registers A-D, event flag collection and interrupt generation.
// Assumes event inputs are single-cycle pulses and that a write to B and a
// read of C never share a cycle (one bus access per cycle).
module rtcx_ctrl_regs
    import rtcx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sys_rst,
    input  logic  wr_a,
    input  logic  wr_b,
    input  logic  rd_c,
    input  byte_t wdata,
    input  evt_t  evt,
    input  logic  upd_busy,
    output byte_t reg_a,
    output byte_t reg_b,
    output byte_t reg_c,
    output byte_t reg_d,
    output logic  irq_o
);
    logic       busy_q;
    logic [6:0] a_lo_q;
    byte_t      b_q, b_nxt;
    logic [2:0] flg_q, flg_base, flg_nxt, raw, fresh, en_nxt;
    logic       sum_q, sum_base, sum_nxt, fire;

    // Track the busy level from timekeeping; never bus-writable.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= upd_busy;
    end

    // Register A writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_lo_q <= A_POR[6:0];
        else if (wr_a) a_lo_q <= wdata[6:0];
    end

    // Next value of B: system reset clears the interrupt-related enables.
    always_comb begin
        b_nxt = b_q;
        if (wr_b)
            b_nxt = wdata;
        if (sys_rst) begin
            b_nxt[B_PIE] = 1'b0;
            b_nxt[B_AIE] = 1'b0;
            b_nxt[B_SQW] = 1'b0;
        end
    end

    // Register B storage.
    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= B_POR;
        else        b_q <= b_nxt;
    end

    // Flag and summary next-state from events, reads and B writes.
    always_comb begin
        en_nxt   = {b_nxt[B_PIE], b_nxt[B_AIE], b_nxt[B_UIE]};
        raw      = {evt.per & b_nxt[B_PIE], evt.alm, evt.upd};
        flg_base = rd_c ? 3'b000 : flg_q;
        fresh    = raw & ~flg_base;
        fire     = |(fresh & en_nxt);
        flg_nxt  = flg_base | raw;
        if (wr_b)      sum_base = |(en_nxt & flg_q);
        else if (rd_c) sum_base = 1'b0;
        else           sum_base = sum_q;
        sum_nxt = sum_base | fire;
        if (sys_rst) begin
            flg_nxt = 3'b000;
            sum_nxt = 1'b0;
        end
    end

    // Register C storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= C_POR[6:4];
            sum_q <= C_POR[7];
        end else begin
            flg_q <= flg_nxt;
            sum_q <= sum_nxt;
        end
    end

    assign reg_a = {busy_q, a_lo_q};
    assign reg_b = b_q;
    assign reg_c = {sum_q, flg_q, 4'b0000};
    assign reg_d = D_VAL;
    assign irq_o = sum_q;

    // R4: a quiet read of C empties it and drops the line
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !evt.per && !evt.alm && !evt.upd && !sys_rst)
        |=> (reg_c == 8'h00 && !irq_o));

    // R5/R6: the line is only ever high with an enabled pending flag
    a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|({reg_b[B_PIE], reg_b[B_AIE], reg_b[B_UIE]} & reg_c[6:4])));

    // R5: a new enabled alarm event raises the line
    a_r5_alarm_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.alm && reg_b[B_AIE] && !wr_b && !sys_rst) |=> irq_o);

    // R7: A write keeps the busy bit from the input, stores the rest
    a_r7_busy_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (reg_a[6:0] == $past(wdata[6:0]) && reg_a[A_BUSY] == $past(upd_busy)));

    // R8: periodic flag cannot rise while periodic enable is off
    a_r8_pie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_b[B_PIE] && !wr_b && !rd_c && !sys_rst)
        |=> (reg_c[C_PER] == $past(reg_c[C_PER])));

    // R10: system reset clears enables, flags and the line
    a_r10_sys_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> (!irq_o && reg_c == 8'h00 && !reg_b[B_PIE] && !reg_b[B_AIE] && !reg_b[B_SQW]));
endmodule

// File: rtl/rtcx_regif.sv
// Top of the indexed RTC register interface: bus port, control registers,
// general-purpose memory and the registered read-data path.
// Assumes one bus access per strobe; read data is valid one cycle later.
module rtcx_regif
    import rtcx_pkg::*;
#(
    parameter int IDX_W     = 7,
    parameter int CTRL_BASE = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_rst,
    input  logic       bus_en,
    input  logic       bus_wr,
    input  logic       bus_odd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_periodic,
    input  logic       tick_alarm,
    input  logic       tick_update,
    input  logic       upd_busy,
    output logic       irq,
    output logic [3:0] rate_sel,
    output logic [2:0] div_sel,
    output logic       set_mode,
    output logic       sqw_en,
    output logic       bin_mode,
    output logic       hr24
);
    logic [IDX_W-1:0] idx;
    rsel_e            sel;
    logic             data_wr, data_rd;
    byte_t            reg_a, reg_b, reg_c, reg_d, mem_rd, rd_sel, rdata_q;
    evt_t             evt;

    assign evt = '{per: tick_periodic, alm: tick_alarm, upd: tick_update};

    rtcx_bus_port #(.IDX_W(IDX_W), .CTRL_BASE(CTRL_BASE)) port_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (bus_en),
        .acc_wr    (bus_wr),
        .acc_odd   (bus_odd),
        .idx_wdata (bus_wdata[IDX_W-1:0]),
        .idx       (idx),
        .sel       (sel),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    rtcx_ctrl_regs ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst  (sys_rst),
        .wr_a     (data_wr && sel == SEL_A),
        .wr_b     (data_wr && sel == SEL_B),
        .rd_c     (data_rd && sel == SEL_C),
        .wdata    (bus_wdata),
        .evt      (evt),
        .upd_busy (upd_busy),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .reg_c    (reg_c),
        .reg_d    (reg_d),
        .irq_o    (irq)
    );

    rtcx_gp_mem #(.IDX_W(IDX_W)) mem_i (
        .clk   (clk),
        .wr_en (data_wr && sel == SEL_MEM),
        .addr  (idx),
        .wdata (bus_wdata),
        .rdata (mem_rd)
    );

    // Pick the byte addressed by the latched index.
    always_comb begin
        case (sel)
            SEL_A:   rd_sel = reg_a;
            SEL_B:   rd_sel = reg_b;
            SEL_C:   rd_sel = reg_c;
            SEL_D:   rd_sel = reg_d;
            default: rd_sel = mem_rd;
        endcase
    end

    // Register read data; the index port always reads all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= 8'h00;
        else if (bus_en && !bus_wr)
            rdata_q <= bus_odd ? rd_sel : 8'hFF;
    end

    assign bus_rdata = rdata_q;
    assign rate_sel  = reg_a[3:0];
    assign div_sel   = reg_a[6:4];
    assign set_mode  = reg_b[B_SET];
    assign sqw_en    = reg_b[B_SQW];
    assign bin_mode  = reg_b[B_BIN];
    assign hr24      = reg_b[B_H24];

    // R2: index-port reads return all ones
    a_r2_index_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && !bus_odd) |=> (bus_rdata == 8'hFF));

    // R3: data writes aimed at C leave it untouched when nothing else acts
    a_r3_c_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel == SEL_C && !tick_periodic && !tick_alarm && !tick_update && !sys_rst)
        |=> $stable(reg_c));
endmodule

// File: tb/rtcx_regif_tb_top.sv
`timescale 1ns/1ps
module rtcx_regif_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0, bus_odd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_periodic = 1'b0, tick_alarm = 1'b0, tick_update = 1'b0;
    logic       upd_busy = 1'b0;
    logic       irq;
    logic [3:0] rate_sel;
    logic [2:0] div_sel;
    logic       set_mode, sqw_en, bin_mode, hr24;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtcx_regif dut_i (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_odd(bus_odd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_periodic(tick_periodic), .tick_alarm(tick_alarm), .tick_update(tick_update),
        .upd_busy(upd_busy), .irq(irq), .rate_sel(rate_sel), .div_sel(div_sel),
        .set_mode(set_mode), .sqw_en(sqw_en), .bin_mode(bin_mode), .hr24(hr24)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic bus_cycle(input logic wr, input logic odd, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_odd = odd; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        bus_cycle(1'b1, 1'b0, idx);
        bus_cycle(1'b1, 1'b1, d);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
        bus_cycle(1'b1, 1'b0, idx);
        bus_cycle(1'b0, 1'b1, 8'h00);
        d = bus_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        tick_periodic = (which == 0);
        tick_alarm    = (which == 1);
        tick_update   = (which == 2);
        @(negedge clk);
        tick_periodic = 1'b0; tick_alarm = 1'b0; tick_update = 1'b0;
    endtask

    task automatic t_powerup;
        logic [7:0] v;
        rd_reg(8'h0A, v); check("R9 A after power-up", v, 8'h26);
        rd_reg(8'h0B, v); check("R9 B after power-up", v, 8'h02);
        rd_reg(8'h0C, v); check("R9 C after power-up", v, 8'h00);
        rd_reg(8'h0D, v); check("R9 D after power-up", v, 8'h80);
        check("R9 irq low after power-up", {7'b0, irq}, 8'h00);
        bus_cycle(1'b0, 1'b0, 8'h00);
        check("R2 index port read", bus_rdata, 8'hFF);
    endtask

    task automatic t_index_mem;
        logic [7:0] v;
        wr_reg(8'h20, 8'h5A);
        wr_reg(8'h40, 8'hC3);
        rd_reg(8'hA0, v); check("R1 alias 0xA0 to 0x20", v, 8'h5A);
        rd_reg(8'h40, v); check("R1 memory byte 0x40", v, 8'hC3);
    endtask

    task automatic t_ro_regs;
        logic [7:0] v;
        wr_reg(8'h0C, 8'hFF);
        wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0C, v); check("R3 C write ignored", v, 8'h00);
        rd_reg(8'h0D, v); check("R3 D write ignored", v, 8'h80);
        check("R3 irq untouched", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_event_irq;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h22);
        pulse(1);
        check("R5 enabled alarm raises irq", {7'b0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R4 R11 C contents on read", v, 8'hA0);
        check("R4 irq dropped by read", {7'b0, irq}, 8'h00);
        rd_reg(8'h0C, v); check("R4 C cleared by read", v, 8'h00);
    endtask

    task automatic t_late_enable;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h02);
        pulse(2);
        check("R5 disabled update no irq", {7'b0, irq}, 8'h00);
        wr_reg(8'h0B, 8'h12);
        check("R6 matching enable raises irq", {7'b0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R6 C after late enable", v, 8'h90);
        wr_reg(8'h0B, 8'h02);
        pulse(2);
        wr_reg(8'h0B, 8'h22);
        check("R6 non-matching enable no irq", {7'b0, irq}, 8'h00);
        rd_reg(8'h0C, v); check("R6 flag kept, no summary", v, 8'h10);
        pulse(1);
        check("R5 alarm raises irq", {7'b0, irq}, 8'h01);
        wr_reg(8'h0B, 8'h02);
        check("R6 disabling write lowers irq", {7'b0, irq}, 8'h00);
        rd_reg(8'h0C, v); check("R6 summary cleared, flag kept", v, 8'h20);
    endtask

    task automatic t_periodic;
        logic [7:0] v;
        wr_reg(8'h0A, 8'h2F);
        check("R8 rate_sel output", {4'b0, rate_sel}, 8'h0F);
        rd_reg(8'h0A, v); check("R7 A written bits", v, 8'h2F);
        wr_reg(8'h0B, 8'h02);
        pulse(0);
        rd_reg(8'h0C, v); check("R8 periodic dropped when disabled", v, 8'h00);
        wr_reg(8'h0B, 8'h42);
        pulse(0);
        check("R8 periodic enabled irq", {7'b0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R8 periodic flags", v, 8'hC0);
    endtask

    task automatic t_busy;
        logic [7:0] v;
        upd_busy = 1'b1;
        wr_reg(8'h0A, 8'h25);
        rd_reg(8'h0A, v); check("R7 busy bit shown", v, 8'hA5);
        upd_busy = 1'b0;
        wr_reg(8'h0A, 8'hA6);
        rd_reg(8'h0A, v); check("R7 busy bit not writable", v, 8'h26);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h22);
        pulse(1);
        bus_cycle(1'b1, 1'b0, 8'h0C);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_odd = 1'b1; tick_alarm = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; tick_alarm = 1'b0;
        check("R12 read returns old C", bus_rdata, 8'hA0);
        check("R12 coinciding event raises irq", {7'b0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R12 coinciding event kept", v, 8'hA0);
    endtask

    task automatic t_sysrst;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h7E);
        pulse(1);
        check("R10 irq before system reset", {7'b0, irq}, 8'h01);
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
        check("R10 irq lowered", {7'b0, irq}, 8'h00);
        check("R10 sqw_en cleared", {7'b0, sqw_en}, 8'h00);
        rd_reg(8'h0B, v); check("R10 B enables cleared", v, 8'h16);
        rd_reg(8'h0C, v); check("R10 C cleared", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_powerup();
        t_index_mem();
        t_ro_regs();
        t_event_irq();
        t_late_enable();
        t_periodic();
        t_busy();
        t_collide();
        t_sysrst();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule